// File: doc/BRIEF.md
# Programmable Logic Cell with Second-Level Combiner

This block models one tile of a programmable logic fabric. Two independent lookup tables, F and G, each take `LUT_K` inputs and hold a truth table of 2^`LUT_K` bits. A third 3-input table, H, sits behind them. Each of H's two lower inputs is taken either from a table output or from a pin of its own. Its top input always comes from a pin. When H combines F and G with one external signal, a single cell can realise certain functions of up to 2·`LUT_K`+1 variables.

Two flip-flops each pick a data source from their configuration. The source is F, G, H or a dedicated direct pin. A flip-flop can therefore retime a table output, or serve as a plain register or shift stage while the tables do unrelated work. A carry mode turns F into a full-adder sum. In that mode the carry out goes straight to the neighbouring cell and uses no general routing.

All truth tables and selects live in one configuration word. The word is shifted in serially, and it takes effect only when a load strobe copies it into the active copy.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `rst_n` is low, both flip-flops read 0 and the active configuration is all zeros. In that state `f_out`, `g_out` and `h_out` are 0, and `cout` equals `cin`.
- R2: Outside carry mode, `f_out` is bit `f_in` of the F truth table. `g_out` is always bit `g_in` of the G truth table.
- R3: `h_out` is bit {b2,b1,b0} of the H truth table. b2 is `h_in[2]`. b1 is `h_in[1]` when the H1-external bit is 1, else `g_out`. b0 is `h_in[0]` when the H0-external bit is 1, else `f_out`.
- R4: When the carry-enable bit is 1, `f_out` = `f_in[0]` ^ `f_in[1]` ^ `cin`, and `cout` is the majority of those three signals. When the bit is 0, `cout` equals `cin`.
- R5: At every rising clock edge, flip-flop i loads the source named by its 2-bit select. The codes are 0 = `f_out`, 1 = `g_out`, 2 = `h_out` and 3 = `d_in[i]`. Flip-flop 0 drives `q[0]` and flip-flop 1 drives `q[1]`.
- R6: While `cfg_en` is high, each rising edge shifts `cfg_bit` into bit 0 of the shadow word and moves every bit up by one. The first bit shifted in therefore ends at the top. The word layout, from bit 0 upward, is: F table (16 bits, [15:0]), G table [31:16], H table [39:32], H0-external [40], H1-external [41], flip-flop 0 select [43:42], flip-flop 1 select [45:44], carry-enable [46].
- R7: Shifting without a load strobe leaves every output driven by the previously loaded configuration.
- R8: A rising edge with `cfg_load` high copies the shadow word as it stood before that edge, even when `cfg_en` shifts on the same edge. The flip-flops capture on that same edge under the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration shadow word |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy shadow word into active configuration |
| f_in | input | LUT_K | F table address |
| g_in | input | LUT_K | G table address |
| h_in | input | 3 | Direct inputs to the H table |
| d_in | input | 2 | Direct data inputs for the two flip-flops |
| cin | input | 1 | Carry from the neighbouring cell |
| f_out | output | 1 | F result (sum in carry mode) |
| g_out | output | 1 | G result |
| h_out | output | 1 | H result |
| q | output | 2 | Flip-flop outputs |
| cout | output | 1 | Carry to the neighbouring cell |

## Verification
Two things can fall on one clock edge: a configuration load and a flip-flop capture. A shift and a load can also coincide. The bench first loads a word that routes flip-flop 0 to its direct pin. It then shifts in a second word that routes flip-flop 0 to a constant-zero F table, and raises `cfg_load` and `cfg_en` on the same edge with the direct pin at 1. The flip-flop must show the direct value, and the outputs must follow the pre-shift word. A later bare load must expose the word moved up by one bit.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    SRC_F      = 2'd0,
    SRC_G      = 2'd1,
    SRC_H      = 2'd2,
    SRC_DIRECT = 2'd3
  } ff_src_e;

  localparam int unsigned H_K = 3;

  // total configuration bits for a given table width
  function automatic int unsigned cfg_width(input int unsigned k);
    return 2 * (1 << k) + (1 << H_K) + 2 + 2 * 2 + 1;
  endfunction

endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] tt,
  input  logic [K-1:0]      sel,
  output logic              o
);
  always_comb o = tt[sel];
endmodule

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int unsigned W = 47
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         load,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  logic [W-1:0] shadow_d;
  logic [W-1:0] active_d;

  always_comb begin
    shadow_d = {shadow_q[W-2:0], shift_bit};
    active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shift_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (load) begin
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/lc_carry.sv
module lc_carry (
  input  logic en,
  input  logic a,
  input  logic b,
  input  logic cin,
  input  logic lut_f,
  output logic f_res,
  output logic cout
);
  logic sum;
  logic maj;

  always_comb begin
    sum   = a ^ b ^ cin;
    maj   = (a & b) | (a & cin) | (b & cin);
    f_res = en ? sum : lut_f;
    cout  = en ? maj : cin;
  end
endmodule

// File: rtl/lc_ff_stage.sv
module lc_ff_stage
  import lc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ff_src_e src,
  input  logic    f_v,
  input  logic    g_v,
  input  logic    h_v,
  input  logic    d_v,
  output logic    q
);
  logic q_d;

  always_comb begin
    unique case (src)
      SRC_F:   q_d = f_v;
      SRC_G:   q_d = g_v;
      SRC_H:   q_d = h_v;
      default: q_d = d_v;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lc_pkg::*;
#(
  parameter int unsigned LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             cfg_load,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic [2:0]       h_in,
  input  logic [1:0]       d_in,
  input  logic             cin,
  output logic             f_out,
  output logic             g_out,
  output logic             h_out,
  output logic [1:0]       q,
  output logic             cout
);
  localparam int unsigned TT_W   = 1 << LUT_K;
  localparam int unsigned HT_W   = 1 << H_K;
  localparam int unsigned OFF_F  = 0;
  localparam int unsigned OFF_G  = OFF_F + TT_W;
  localparam int unsigned OFF_H  = OFF_G + TT_W;
  localparam int unsigned OFF_HX = OFF_H + HT_W;
  localparam int unsigned OFF_S0 = OFF_HX + 2;
  localparam int unsigned OFF_CY = OFF_S0 + 4;
  localparam int unsigned CFG_W  = cfg_width(LUT_K);

  logic [CFG_W-1:0] shadow_cfg;
  logic [CFG_W-1:0] active_cfg;

  lc_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_bit(cfg_bit),
    .load     (cfg_load),
    .shadow_q (shadow_cfg),
    .active_q (active_cfg)
  );

  // first-level tables: index 0 is F, index 1 is G
  logic [1:0][TT_W-1:0]  lut_tt;
  logic [1:0][LUT_K-1:0] lut_sel;
  logic [1:0]            lut_o;

  always_comb begin
    lut_tt[0]  = active_cfg[OFF_F +: TT_W];
    lut_tt[1]  = active_cfg[OFF_G +: TT_W];
    lut_sel[0] = f_in;
    lut_sel[1] = g_in;
  end

  for (genvar i = 0; i < 2; i++) begin : g_lut
    lc_lut #(.K(LUT_K)) u_lut (
      .tt (lut_tt[i]),
      .sel(lut_sel[i]),
      .o  (lut_o[i])
    );
  end

  logic f_res;
  lc_carry u_carry (
    .en   (active_cfg[OFF_CY]),
    .a    (f_in[0]),
    .b    (f_in[1]),
    .cin  (cin),
    .lut_f(lut_o[0]),
    .f_res(f_res),
    .cout (cout)
  );

  // second-level combiner
  logic [H_K-1:0] h_idx;
  logic           h_res;
  always_comb begin
    h_idx[0] = active_cfg[OFF_HX]     ? h_in[0] : f_res;
    h_idx[1] = active_cfg[OFF_HX + 1] ? h_in[1] : lut_o[1];
    h_idx[2] = h_in[2];
  end

  lc_lut #(.K(H_K)) u_hlut (
    .tt (active_cfg[OFF_H +: HT_W]),
    .sel(h_idx),
    .o  (h_res)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ff
    lc_ff_stage u_ff (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (ff_src_e'(active_cfg[OFF_S0 + 2*i +: 2])),
      .f_v  (f_res),
      .g_v  (lut_o[1]),
      .h_v  (h_res),
      .d_v  (d_in[i]),
      .q    (q[i])
    );
  end

  always_comb begin
    f_out = f_res;
    g_out = lut_o[1];
    h_out = h_res;
  end
endmodule

// File: rtl/lc_cell_chk.sv
module lc_cell_chk
  import lc_pkg::*;
#(
  parameter int unsigned LUT_K = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_en,
  input logic                         cfg_bit,
  input logic                         cfg_load,
  input logic [LUT_K-1:0]             f_in,
  input logic [1:0]                   d_in,
  input logic                         cin,
  input logic                         f_out,
  input logic [1:0]                   q,
  input logic                         cout,
  input logic [cfg_width(LUT_K)-1:0] shadow_cfg,
  input logic [cfg_width(LUT_K)-1:0] active_cfg
);
  localparam int unsigned W      = cfg_width(LUT_K);
  localparam int unsigned OFF_S0 = 2 * (1 << LUT_K) + (1 << H_K) + 2;
  localparam int unsigned OFF_CY = OFF_S0 + 4;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (q == 2'b00 && active_cfg == '0);
    end
  end

  p_carry_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_cfg[OFF_CY] |-> (f_out == (f_in[0] ^ f_in[1] ^ cin)) &&
      (cout == ((f_in[0] & f_in[1]) | (cin & (f_in[0] | f_in[1])))));

  p_direct0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && ($past(active_cfg[OFF_S0 +: 2]) == 2'd3) |-> q[0] == $past(d_in[0]));

  p_direct1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && ($past(active_cfg[OFF_S0 + 2 +: 2]) == 2'd3) |-> q[1] == $past(d_in[1]));

  p_shift_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cfg_en) |-> shadow_cfg == {$past(shadow_cfg[W-2:0]), $past(cfg_bit)});

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(cfg_load) |-> $stable(active_cfg));

  p_load_snapshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cfg_load) |-> active_cfg == $past(shadow_cfg));
endmodule

bind cfg_logic_cell lc_cell_chk #(.LUT_K(LUT_K)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_bit   (cfg_bit),
  .cfg_load  (cfg_load),
  .f_in      (f_in),
  .d_in      (d_in),
  .cin       (cin),
  .f_out     (f_out),
  .q         (q),
  .cout      (cout),
  .shadow_cfg(shadow_cfg),
  .active_cfg(active_cfg)
);

// File: tb/cfg_logic_cell_tb_top.sv
module cfg_logic_cell_tb_top;
  localparam int PERIOD = 10;
  localparam int W      = 47;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en, cfg_bit, cfg_load;
  logic [3:0] f_in, g_in;
  logic [2:0] h_in;
  logic [1:0] d_in;
  logic       cin;
  logic       f_out, g_out, h_out, cout;
  logic [1:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [W-1:0] cur_cfg;
  logic [31:0]  rng = 32'h1234_5679;

  always #(PERIOD/2) clk = ~clk;

  cfg_logic_cell #(.LUT_K(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_load(cfg_load), .f_in(f_in), .g_in(g_in), .h_in(h_in),
    .d_in(d_in), .cin(cin), .f_out(f_out), .g_out(g_out), .h_out(h_out),
    .q(q), .cout(cout)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    return s;
  endfunction

  function automatic logic [31:0] rnd();
    rng = xs(rng);
    return rng;
  endfunction

  function automatic logic [W-1:0] mk_cfg(input logic [15:0] ft, input logic [15:0] gt,
      input logic [7:0] ht, input logic hx0, input logic hx1, input logic [1:0] s0,
      input logic [1:0] s1, input logic cy);
    return {cy, s1, s0, hx1, hx0, ht, gt, ft};
  endfunction

  // {next q1, next q0, cout, h, g, f}
  function automatic logic [5:0] model(input logic [W-1:0] c, input logic [3:0] fi,
      input logic [3:0] gi, input logic [2:0] hi, input logic ci, input logic [1:0] d);
    logic fo, go, ho, co;
    logic [2:0] hx;
    logic [1:0] nq;
    if (c[46]) begin
      fo = fi[0] ^ fi[1] ^ ci;
      co = (fi[0] + fi[1] + ci) >= 2;
    end else begin
      fo = c[fi];
      co = ci;
    end
    go = c[16 + gi];
    hx = {hi[2], c[41] ? hi[1] : go, c[40] ? hi[0] : fo};
    ho = c[32 + hx];
    for (int i = 0; i < 2; i++) begin
      case (c[42 + 2*i +: 2])
        2'd0: nq[i] = fo;
        2'd1: nq[i] = go;
        2'd2: nq[i] = ho;
        default: nq[i] = d[i];
      endcase
    end
    return {nq, co, ho, go, fo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_in(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_bit = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic load_pulse();
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // full sweep of combinational outputs against the model
  task automatic sweep(input string req);
    for (int v = 0; v < 4096; v++) begin
      logic [5:0] e;
      f_in = v[3:0]; g_in = v[7:4]; h_in = v[10:8]; cin = v[11];
      #1;
      e = model(cur_cfg, f_in, g_in, h_in, cin, d_in);
      check({cout, h_out, g_out, f_out} == e[3:0], req,
            {28'd0, cout, h_out, g_out, f_out}, {28'd0, e[3:0]});
    end
  endtask

  task automatic ff_run(input int n);
    logic [1:0] exp_q = 2'b00;
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      @(negedge clk);
      if (i > 0) check(q == exp_q, "R5 flip-flop source", {30'd0, q}, {30'd0, exp_q});
      r = rnd();
      f_in = r[3:0]; g_in = r[7:4]; h_in = r[10:8]; cin = r[11]; d_in = r[13:12];
      exp_q = model(cur_cfg, f_in, g_in, h_in, cin, d_in)[5:4];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] wa, wb, wc;
    rst_n = 1'b0; cfg_en = 0; cfg_bit = 0; cfg_load = 0;
    f_in = 0; g_in = 0; h_in = 3'b111; d_in = 2'b11; cin = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(q == 2'b00, "R1 q in reset", {30'd0, q}, 32'd0);
    check({h_out, g_out, f_out} == 3'b000, "R1 tables in reset", {29'd0, h_out, g_out, f_out}, 32'd0);
    check(cout == 1'b1, "R1 cout follows cin=1", {31'd0, cout}, 32'd1);
    cin = 1'b0; #1;
    check(cout == 1'b0, "R1 cout follows cin=0", {31'd0, cout}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6: every H select and carry setting, all flip-flop sources
    for (int k = 0; k < 8; k++) begin
      logic [31:0] r1, r2;
      r1 = rnd(); r2 = rnd();
      cur_cfg = mk_cfg(r1[15:0], r1[31:16], r2[7:0], k[0], k[1], k[1:0],
                       2'(3 - k[1:0]), k[2]);
      shift_in(cur_cfg);
      load_pulse();
      sweep("R2/R3/R4/R6 combinational");
      ff_run(24);
    end

    // R7: shift a different word without loading
    wc = ~cur_cfg;
    shift_in(wc);
    sweep("R7 shift without load");
    load_pulse();
    cur_cfg = wc;
    sweep("R7 after load");

    // R8: load and shift on one edge, flip-flop captures under old word
    wa = mk_cfg(16'hA5C3, 16'h0FF0, 8'h96, 1'b0, 1'b0, 2'd3, 2'd3, 1'b0);
    shift_in(wa);
    load_pulse();
    cur_cfg = wa;
    wb = mk_cfg(16'h0000, 16'h3C3C, 8'h5A, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0);
    shift_in(wb);
    @(negedge clk);
    d_in = 2'b11; f_in = 4'h0;
    cfg_load = 1'b1; cfg_en = 1'b1; cfg_bit = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0; cfg_en = 1'b0;
    check(q[0] == 1'b1, "R8 capture under old select", {31'd0, q[0]}, 32'd1);
    cur_cfg = wb;
    d_in = 2'b11;
    sweep("R8 pre-shift word applied");
    @(negedge clk);
    @(negedge clk);
    check(q[0] == 1'b0, "R5 new select takes F", {31'd0, q[0]}, 32'd0);
    load_pulse();
    cur_cfg = {wb[W-2:0], 1'b1};
    sweep("R8/R6 shifted word on next load");

    finish_run();
  end
endmodule